// File: doc/BRIEF.md
# Speculative Store Gate

This block holds the stores a core issues inside a speculative region and keeps them away from memory until the region is confirmed. Each accepted store (address, data, byte enables) is appended to an in-order queue. A commit strobe marks every store held so far as released. Released entries then drain to memory in the background, oldest first, over a valid/ready write port. A rollback strobe throws away every store that has not been released. Entries that are already released stay and keep draining.

While stores wait in the queue, loads from the core must still see them. A lookup port compares a load address and byte mask with every held entry, released or not. The youngest entry that touches the requested bytes decides the result. If that entry covers all of the requested bytes, its data is forwarded. If it covers only some of them, a conflict is reported so that the core can wait.

The queue depth defaults to 16 entries. Commit only moves a boundary pointer, so it never makes the core wait.

Top module: `spec_store_gate`

## Requirements
- R1: A store that has not been committed never appears on the memory write port. With only uncommitted entries held, `mem_valid` stays low.
- R2: A commit in cycle t releases every store accepted up to and including cycle t. `mem_valid` is high from cycle t+1 until all of them have been handed over, and exactly that many handshakes occur.
- R3: A rollback without commit removes every uncommitted entry, including a store offered in the same cycle, and keeps every committed entry. When commit and rollback arrive together, the commit wins and the rollback has no effect.
- R4: Committed entries leave oldest first, one per cycle in which `mem_valid` and `mem_ready` are both high. While `mem_ready` is low, `mem_addr`, `mem_data` and `mem_be` hold steady.
- R5: A commit never lowers `st_ready`. A store offered in the same cycle as a commit is accepted whenever the queue is not full.
- R6: The queue holds 16 entries. `st_ready` is low exactly when all 16 are occupied. A store offered while `st_ready` is low is ignored. A slot freed by a drain handshake is usable from the next cycle.
- R7: A store accepted in the same cycle as a commit counts as committed and drains without any further commit.
- R8: Within the same cycle, the lookup port checks the entries held at the start of that cycle. The deciding entry is the youngest one whose address equals `ld_addr` and whose byte enables share at least one bit with `ld_be`. If that entry's byte enables include every bit of `ld_be`, then `ld_hit` is high and `ld_data` carries that entry's data.
- R9: If the deciding entry covers only some of the bits of `ld_be`, then `ld_conflict` is high and `ld_hit` is low. If no entry overlaps, both are low. `ld_hit` and `ld_conflict` are never high together.
- R10: After reset the queue is empty: `st_ready` is high, `mem_valid` is low, and lookups miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_valid | input | 1 | Core offers a store |
| st_ready | output | 1 | Queue has a free entry |
| st_addr | input | AW (16) | Store word address |
| st_data | input | DW (32) | Store data |
| st_be | input | DW/8 (4) | Store byte enables |
| commit | input | 1 | Release all held stores |
| rollback | input | 1 | Discard all unreleased stores |
| mem_valid | output | 1 | A released entry is offered to memory |
| mem_ready | input | 1 | Memory accepts the offered entry |
| mem_addr | output | AW (16) | Address of the oldest released entry |
| mem_data | output | DW (32) | Data of the oldest released entry |
| mem_be | output | DW/8 (4) | Byte enables of the oldest released entry |
| ld_addr | input | AW (16) | Lookup word address |
| ld_be | input | DW/8 (4) | Lookup byte mask |
| ld_hit | output | 1 | Youngest overlapping entry fully covers the mask |
| ld_data | output | DW (32) | Forwarded data when `ld_hit` is high |
| ld_conflict | output | 1 | Youngest overlapping entry covers the mask only partly |

## Verification
The lookup outputs, `st_ready`, and the memory port payload depend combinationally on the queue state at the start of a cycle, so they are compared in the same cycle as the stimulus. The effects of a store, commit, rollback or drain handshake show up one clock later. The bench drives every input just after a falling edge and samples one nanosecond later, before the next rising edge. It then advances its queue model as the edge would, so each comparison lines up with the state that edge produces. Directed phases check the outcome of commit, rollback and same-cycle cases in the cycle that follows. A lookup sweep covers every byte mask at several addresses.

// File: rtl/ssg_pkg.sv
package ssg_pkg;
  typedef enum logic [1:0] {
    LK_MISS     = 2'd0,
    LK_HIT      = 2'd1,
    LK_CONFLICT = 2'd2
  } lk_res_e;
endpackage

// File: rtl/ssg_ptr_ctrl.sv
module ssg_ptr_ctrl #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned PW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          st_valid,
  input  logic          commit,
  input  logic          rollback,
  input  logic          mem_ready,
  output logic          st_ready,
  output logic          wr_en,
  output logic [PW-1:0] wr_slot,
  output logic [PW-1:0] head_slot,
  output logic          mem_valid,
  output logic [PW:0]   occ,
  output logic [PW:0]   n_unc
);
  logic [PW:0] head_q, head_d;
  logic [PW:0] cmt_q,  cmt_d;
  logic [PW:0] tail_q, tail_d;
  logic [PW:0] n_com;
  logic        drain_fire;

  always_comb begin
    occ        = tail_q - head_q;
    n_com      = cmt_q - head_q;
    n_unc      = tail_q - cmt_q;
    st_ready   = (occ != (PW+1)'(DEPTH));
    mem_valid  = (n_com != '0);
    drain_fire = mem_valid && mem_ready;
    wr_en      = st_valid && st_ready && (commit || !rollback);
    wr_slot    = tail_q[PW-1:0];
    head_slot  = head_q[PW-1:0];

    head_d = head_q + (PW+1)'(drain_fire);
    tail_d = tail_q + (PW+1)'(wr_en);
    if (rollback && !commit) begin
      tail_d = cmt_q;
    end
    cmt_d = commit ? tail_d : cmt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      cmt_q  <= '0;
      tail_q <= '0;
    end else begin
      head_q <= head_d;
      cmt_q  <= cmt_d;
      tail_q <= tail_d;
    end
  end
endmodule

// File: rtl/ssg_store_ram.sv
module ssg_store_ram #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned AW    = 16,
  parameter int unsigned DW    = 32,
  localparam int unsigned BEW  = DW / 8,
  localparam int unsigned PW   = $clog2(DEPTH)
) (
  input  logic           clk,
  input  logic           wr_en,
  input  logic [PW-1:0]  wr_slot,
  input  logic [AW-1:0]  wr_addr,
  input  logic [DW-1:0]  wr_data,
  input  logic [BEW-1:0] wr_be,
  output logic [AW-1:0]  ent_addr [DEPTH],
  output logic [DW-1:0]  ent_data [DEPTH],
  output logic [BEW-1:0] ent_be   [DEPTH]
);
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic slot_en;
    assign slot_en = wr_en && (wr_slot == PW'(i));
    always_ff @(posedge clk) begin
      if (slot_en) begin
        ent_addr[i] <= wr_addr;
        ent_data[i] <= wr_data;
        ent_be[i]   <= wr_be;
      end
    end
  end
endmodule

// File: rtl/ssg_lookup.sv
module ssg_lookup
  import ssg_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned AW    = 16,
  parameter int unsigned DW    = 32,
  localparam int unsigned BEW  = DW / 8,
  localparam int unsigned PW   = $clog2(DEPTH)
) (
  input  logic [AW-1:0]  ent_addr [DEPTH],
  input  logic [DW-1:0]  ent_data [DEPTH],
  input  logic [BEW-1:0] ent_be   [DEPTH],
  input  logic [PW-1:0]  head_slot,
  input  logic [PW:0]    occ,
  input  logic [AW-1:0]  ld_addr,
  input  logic [BEW-1:0] ld_be,
  output logic           ld_hit,
  output logic           ld_conflict,
  output logic [DW-1:0]  ld_data
);
  logic [DEPTH-1:0] overlap;
  logic [DEPTH-1:0] covers;
  logic             found;
  logic [PW-1:0]    sel;
  logic [PW-1:0]    slot;
  lk_res_e          res;

  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign overlap[i] = (ent_addr[i] == ld_addr) && ((ent_be[i] & ld_be) != '0);
    assign covers[i]  = ((ent_be[i] & ld_be) == ld_be);
  end

  // Walk from oldest to youngest; the last overlapping slot seen is the youngest.
  always_comb begin
    found = 1'b0;
    sel   = '0;
    slot  = '0;
    for (int k = 0; k < DEPTH; k++) begin
      slot = head_slot + PW'(k);
      if ((PW+1)'(k) < occ && overlap[slot]) begin
        found = 1'b1;
        sel   = slot;
      end
    end
    if (!found)          res = LK_MISS;
    else if (covers[sel]) res = LK_HIT;
    else                  res = LK_CONFLICT;
  end

  assign ld_hit      = (res == LK_HIT);
  assign ld_conflict = (res == LK_CONFLICT);
  assign ld_data     = ld_hit ? ent_data[sel] : '0;
endmodule

// File: rtl/spec_store_gate.sv
module spec_store_gate #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned AW    = 16,
  parameter int unsigned DW    = 32,
  localparam int unsigned BEW  = DW / 8,
  localparam int unsigned PW   = $clog2(DEPTH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           st_valid,
  output logic           st_ready,
  input  logic [AW-1:0]  st_addr,
  input  logic [DW-1:0]  st_data,
  input  logic [BEW-1:0] st_be,
  input  logic           commit,
  input  logic           rollback,
  output logic           mem_valid,
  input  logic           mem_ready,
  output logic [AW-1:0]  mem_addr,
  output logic [DW-1:0]  mem_data,
  output logic [BEW-1:0] mem_be,
  input  logic [AW-1:0]  ld_addr,
  input  logic [BEW-1:0] ld_be,
  output logic           ld_hit,
  output logic [DW-1:0]  ld_data,
  output logic           ld_conflict
);
  logic           wr_en;
  logic [PW-1:0]  wr_slot;
  logic [PW-1:0]  head_slot;
  logic [PW:0]    occ;
  logic [PW:0]    n_unc;
  logic [AW-1:0]  ent_addr [DEPTH];
  logic [DW-1:0]  ent_data [DEPTH];
  logic [BEW-1:0] ent_be   [DEPTH];

  ssg_ptr_ctrl #(.DEPTH(DEPTH)) i_ptr (
    .clk       (clk),
    .rst_n     (rst_n),
    .st_valid  (st_valid),
    .commit    (commit),
    .rollback  (rollback),
    .mem_ready (mem_ready),
    .st_ready  (st_ready),
    .wr_en     (wr_en),
    .wr_slot   (wr_slot),
    .head_slot (head_slot),
    .mem_valid (mem_valid),
    .occ       (occ),
    .n_unc     (n_unc)
  );

  ssg_store_ram #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) i_ram (
    .clk      (clk),
    .wr_en    (wr_en),
    .wr_slot  (wr_slot),
    .wr_addr  (st_addr),
    .wr_data  (st_data),
    .wr_be    (st_be),
    .ent_addr (ent_addr),
    .ent_data (ent_data),
    .ent_be   (ent_be)
  );

  ssg_lookup #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) i_lkp (
    .ent_addr    (ent_addr),
    .ent_data    (ent_data),
    .ent_be      (ent_be),
    .head_slot   (head_slot),
    .occ         (occ),
    .ld_addr     (ld_addr),
    .ld_be       (ld_be),
    .ld_hit      (ld_hit),
    .ld_conflict (ld_conflict),
    .ld_data     (ld_data)
  );

  assign mem_addr = ent_addr[head_slot];
  assign mem_data = ent_data[head_slot];
  assign mem_be   = ent_be[head_slot];
endmodule

// File: rtl/ssg_checker.sv
module ssg_checker #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned AW    = 16,
  parameter int unsigned DW    = 32,
  localparam int unsigned BEW  = DW / 8,
  localparam int unsigned PW   = $clog2(DEPTH)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           st_valid,
  input logic           st_ready,
  input logic           commit,
  input logic           rollback,
  input logic           mem_valid,
  input logic           mem_ready,
  input logic [AW-1:0]  mem_addr,
  input logic [DW-1:0]  mem_data,
  input logic [BEW-1:0] mem_be,
  input logic           ld_hit,
  input logic           ld_conflict,
  input logic [PW:0]    occ,
  input logic [PW:0]    n_unc
);
  // R1
  mem_rise_after_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_valid) |-> $past(commit));

  // R2
  commit_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit && (n_unc != '0 || (st_valid && st_ready)) |=> mem_valid);

  // R3
  rollback_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rollback && !commit |=> n_unc == '0);

  // R4
  drain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_data) && $stable(mem_be));

  // R6
  occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= (PW+1)'(DEPTH));

  // R9
  lookup_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ld_hit && ld_conflict));
endmodule

bind spec_store_gate ssg_checker #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) i_ssg_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .st_valid    (st_valid),
  .st_ready    (st_ready),
  .commit      (commit),
  .rollback    (rollback),
  .mem_valid   (mem_valid),
  .mem_ready   (mem_ready),
  .mem_addr    (mem_addr),
  .mem_data    (mem_data),
  .mem_be      (mem_be),
  .ld_hit      (ld_hit),
  .ld_conflict (ld_conflict),
  .occ         (occ),
  .n_unc       (n_unc)
);

// File: tb/test_spec_store_gate.sv
module test_spec_store_gate;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        st_valid, st_ready;
  logic [15:0] st_addr;
  logic [31:0] st_data;
  logic [3:0]  st_be;
  logic        commit, rollback;
  logic        mem_valid, mem_ready;
  logic [15:0] mem_addr;
  logic [31:0] mem_data;
  logic [3:0]  mem_be;
  logic [15:0] ld_addr;
  logic [3:0]  ld_be;
  logic        ld_hit, ld_conflict;
  logic [31:0] ld_data;

  int checks = 0;
  int fails  = 0;
  int drained = 0;
  logic [31:0] rng = 32'h1234_5678;

  typedef struct {
    logic [15:0] a;
    logic [31:0] d;
    logic [3:0]  b;
  } ent_t;
  ent_t q[$];
  int   ncom = 0;

  always #4 clk = ~clk;

  spec_store_gate i_spec_store_gate (
    .clk(clk), .rst_n(rst_n),
    .st_valid(st_valid), .st_ready(st_ready),
    .st_addr(st_addr), .st_data(st_data), .st_be(st_be),
    .commit(commit), .rollback(rollback),
    .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_addr(mem_addr), .mem_data(mem_data), .mem_be(mem_be),
    .ld_addr(ld_addr), .ld_be(ld_be),
    .ld_hit(ld_hit), .ld_data(ld_data), .ld_conflict(ld_conflict)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] nxt(input logic [31:0] s);
    logic [31:0] x = s;
    x ^= x << 13; x ^= x >> 17; x ^= x << 5;
    return x;
  endfunction

  // One cycle: drive after the falling edge, compare before the rising edge,
  // then advance the model to the state that rising edge produces.
  task automatic cyc(input bit stv, input logic [15:0] sa, input logic [31:0] sd, input logic [3:0] sbe,
                     input bit cm, input bit rb, input bit mr, input logic [15:0] la, input logic [3:0] lbe);
    int  sz0;
    bit  mv, eh, ec;
    logic [31:0] ed;
    @(negedge clk);
    st_valid = stv; st_addr = sa; st_data = sd; st_be = sbe;
    commit = cm; rollback = rb; mem_ready = mr; ld_addr = la; ld_be = lbe;
    #1;
    sz0 = q.size();
    mv  = (ncom > 0);
    chk(st_ready === (sz0 < DEPTH), "R6 st_ready", 64'(st_ready), 64'(sz0 < DEPTH));
    chk(mem_valid === mv, "R1 mem_valid", 64'(mem_valid), 64'(mv));
    if (mv) begin
      chk(mem_addr === q[0].a && mem_data === q[0].d && mem_be === q[0].b, "R4 drain order",
          {mem_be, mem_addr, 12'h0, mem_data[31:0]} , {q[0].b, q[0].a, 12'h0, q[0].d});
    end
    eh = 1'b0; ec = 1'b0; ed = '0;
    for (int i = sz0 - 1; i >= 0; i--) begin
      if (q[i].a == la && (q[i].b & lbe) != 4'h0) begin
        if ((q[i].b & lbe) == lbe) begin eh = 1'b1; ed = q[i].d; end
        else ec = 1'b1;
        break;
      end
    end
    chk(ld_hit === eh, "R8 ld_hit", 64'(ld_hit), 64'(eh));
    chk(ld_conflict === ec, "R9 ld_conflict", 64'(ld_conflict), 64'(ec));
    if (eh) chk(ld_data === ed, "R8 ld_data", 64'(ld_data), 64'(ed));
    if (mem_valid && mr) drained++;
    if (mv && mr) begin void'(q.pop_front()); ncom--; end
    if (stv && sz0 < DEPTH && (cm || !rb)) q.push_back('{sa, sd, sbe});
    if (cm) ncom = q.size();
    else if (rb) while (q.size() > ncom) void'(q.pop_back());
  endtask

  task automatic idle(input bit mr, input logic [15:0] la, input logic [3:0] lbe);
    cyc(1'b0, 16'h0, 32'h0, 4'h0, 1'b0, 1'b0, mr, la, lbe);
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    st_valid = 0; st_addr = 0; st_data = 0; st_be = 0;
    commit = 0; rollback = 0; mem_ready = 0; ld_addr = 0; ld_be = 4'hF;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R10 reset state
    chk(st_ready === 1'b1, "R10 st_ready", 64'(st_ready), 64'd1);
    chk(mem_valid === 1'b0, "R10 mem_valid", 64'(mem_valid), 64'd0);
    chk(ld_hit === 1'b0 && ld_conflict === 1'b0, "R10 lookup", 64'({ld_hit, ld_conflict}), 64'd0);

    // Fill without commit: nothing reaches memory (R1), full stalls (R6)
    for (int i = 0; i < DEPTH + 2; i++)
      cyc(1'b1, 16'(16'h100 + i), 32'hA000_0000 + 32'(i), 4'hF, 1'b0, 1'b0, 1'b1, 16'h100, 4'hF);
    idle(1'b1, 16'h10F, 4'hF);
    chk(mem_valid === 1'b0, "R1 held", 64'(mem_valid), 64'd0);
    chk(st_ready === 1'b0, "R6 full", 64'(st_ready), 64'd0);

    // Rollback drops everything, including a store in the same cycle (R3)
    cyc(1'b1, 16'h200, 32'hDEAD_0001, 4'hF, 1'b0, 1'b1, 1'b1, 16'h0, 4'hF);
    idle(1'b1, 16'h100, 4'hF);
    chk(ld_hit === 1'b0 && st_ready === 1'b1, "R3 dropped", 64'({ld_hit, st_ready}), 64'd1);
    idle(1'b1, 16'h200, 4'hF);
    chk(ld_hit === 1'b0, "R3 same-cycle store dropped", 64'(ld_hit), 64'd0);

    // Lookup sweep over every mask at several addresses (R8, R9)
    cyc(1'b1, 16'h0, 32'h1111_1111, 4'hF, 0, 0, 0, 0, 0);
    cyc(1'b1, 16'h0, 32'h2222_2222, 4'h3, 0, 0, 0, 0, 0);
    cyc(1'b1, 16'h1, 32'h3333_3333, 4'hC, 0, 0, 0, 0, 0);
    cyc(1'b1, 16'h2, 32'h4444_4444, 4'hF, 0, 0, 0, 0, 0);
    cyc(1'b1, 16'h2, 32'h5555_5555, 4'hF, 0, 0, 0, 0, 0);
    for (int a = 0; a < 4; a++)
      for (int m = 0; m < 16; m++)
        idle(1'b0, 16'(a), 4'(m));
    idle(1'b0, 16'h0, 4'h3);
    chk(ld_hit === 1'b1 && ld_data === 32'h2222_2222, "R8 youngest full cover", 64'(ld_data), 64'h2222_2222);
    idle(1'b0, 16'h0, 4'h6);
    chk(ld_conflict === 1'b1 && ld_hit === 1'b0, "R9 partial younger", 64'({ld_hit, ld_conflict}), 64'd1);

    // Store with commit (R7), commit keeps st_ready (R5), count handshakes (R2)
    cyc(1'b1, 16'h3, 32'h6666_6666, 4'hF, 1'b1, 1'b0, 1'b0, 16'h3, 4'hF);
    chk(st_ready === 1'b1, "R5 commit no stall", 64'(st_ready), 64'd1);
    idle(1'b0, 16'h3, 4'hF);
    chk(mem_valid === 1'b1, "R7 committed with store", 64'(mem_valid), 64'd1);
    drained = 0;
    for (int i = 0; i < 16; i++) idle(1'(i % 3 != 0), 16'h0, 4'hF);
    chk(drained == 6, "R2 release count", 64'(drained), 64'd6);
    chk(mem_valid === 1'b0, "R2 drained", 64'(mem_valid), 64'd0);

    // Committed entries survive a later rollback (R3)
    cyc(1'b1, 16'h10, 32'h7, 4'hF, 0, 0, 0, 0, 0);
    cyc(1'b1, 16'h11, 32'h8, 4'hF, 1, 0, 0, 0, 0);
    cyc(1'b1, 16'h12, 32'h9, 4'hF, 0, 0, 0, 0, 0);
    cyc(1'b1, 16'h13, 32'hA, 4'hF, 0, 1, 0, 0, 0);
    idle(1'b0, 16'h12, 4'hF);
    chk(mem_valid === 1'b1 && ld_hit === 1'b0, "R3 committed kept", 64'({mem_valid, ld_hit}), 64'd2);
    drained = 0;
    for (int i = 0; i < 6; i++) idle(1'b1, 16'h0, 4'hF);
    chk(drained == 2, "R3 survivors drained", 64'(drained), 64'd2);

    // Commit and rollback together: commit wins (R3)
    cyc(1'b1, 16'h20, 32'hB, 4'hF, 0, 0, 0, 0, 0);
    cyc(1'b0, 16'h0, 32'h0, 4'h0, 1, 1, 0, 0, 0);
    idle(1'b0, 16'h20, 4'hF);
    chk(mem_valid === 1'b1 && ld_hit === 1'b1, "R3 commit over rollback", 64'({mem_valid, ld_hit}), 64'd3);

    // Mixed random traffic
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] r0, r1;
      rng = nxt(rng); r0 = rng;
      rng = nxt(rng); r1 = rng;
      cyc(r0[3:0] < 4'd10, {14'h0, r0[5:4]}, r1, r0[11:8],
          r0[15:12] == 4'h0, r0[19:16] == 4'h0, r0[20] | r0[21],
          {14'h0, r1[9:8]}, r1[13:10]);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule